// File: doc/BRIEF.md
# Bus-Tenure Transfer Controller

This block governs one bus-ownership period of a DMA master that moves 32-bit words between local FIFOs and system memory. When work is pending it raises a bus request. Once the grant is sampled, it captures a word-aligned start address and a transfer direction. It then issues a series of single, non-burst transfers to ascending, contiguous addresses. Each transfer has its own address phase followed by a data phase. A data phase ends only when the target signals ready.

The controller decides when the ownership period ends. A mode bit picks one of two policies. In capped mode, the period ends after a programmable number of transfers. In run-on mode, there is no count limit and the period runs until a FIFO watermark condition is met. The watermark check, a bus timer that is reloaded at every grant, preemption by another master and an end-of-packet flag all cut the period short in both modes. In every case the transfer already under way completes first, and the block then pulses a release strobe for one cycle.

Top module: `dma_tenure_ctrl`

## Requirements
- R1: While reset is held and after it is released with no pending work, `frameOut`, `xferValid`, `busRelease` and `busReq` are low and `byteEn` is zero.
- R2: In idle, `busReq` follows `xferPending`. A tenure starts only at a clock edge where both `busGrant` and `xferPending` are high. The first address phase follows in the next cycle, carrying `startAddr` with bits [1:0] forced to zero.
- R3: Each transfer has one address-phase cycle with `frameOut` high, followed directly by a data phase. `frameOut` is never high for two cycles in a row. `byteEn` is 4'hF during data phases and 4'h0 otherwise.
- R4: A transfer completes only at an edge where `tgtReady` is high during the data phase. While `tgtReady` is low, the data phase, the address and the counts hold.
- R5: After each completed transfer that is not the last, the next address phase carries the previous address plus 4.
- R6: `xferWrite` (1 = write to memory from the receive FIFO, 0 = read into the transmit FIFO) is captured at the grant and stays constant for the whole tenure, whatever `dirWrite` does.
- R7: With `cfgRunMode` = 0, a tenure performs at most `cfgXferLimit` transfers. A limit value of 0 selects the default cap of 16.
- R8: At each completion, a read tenure ends if `txLevel` >= `txHighMark`, and a write tenure ends if `rxLevel` <= `rxLowMark`. With `cfgRunMode` = 1 the transfer count is ignored. The watermark test also applies with `cfgRunMode` = 0.
- R9: The bus timer loads `cfgTimerLoad` at the grant and decrements by one every cycle of the tenure, stopping at zero. A completion that occurs while the timer reads zero is the last one.
- R10: A `preempt` or `eopIn` pulse in any address-phase or data-phase cycle of a tenure makes the current or next completion the last one.
- R11: After the final completion, `busRelease` is high for exactly one cycle with `busReq` low, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xferPending | input | 1 | FIFO side has data to move |
| busGrant | input | 1 | Bus ownership granted |
| dirWrite | input | 1 | Direction for the next tenure (1 = write to memory) |
| startAddr | input | 32 | Byte address of the first transfer |
| txLevel | input | 8 | Transmit FIFO fill level |
| txHighMark | input | 8 | Transmit FIFO high watermark |
| rxLevel | input | 8 | Receive FIFO fill level |
| rxLowMark | input | 8 | Receive FIFO low watermark |
| eopIn | input | 1 | End-of-packet flag from the FIFO |
| preempt | input | 1 | Another master is taking the bus |
| tgtReady | input | 1 | Target ready in the data phase |
| cfgRunMode | input | 1 | 0 = capped count, 1 = run to watermark |
| cfgXferLimit | input | 8 | Transfer cap in capped mode (0 means 16) |
| cfgTimerLoad | input | 16 | Bus timer reload value |
| busReq | output | 1 | Bus request |
| frameOut | output | 1 | Address-phase indicator |
| xferValid | output | 1 | Data phase active |
| xferWrite | output | 1 | Direction of the current tenure |
| xferAddr | output | 32 | Address of the current transfer |
| byteEn | output | 4 | Active byte lanes |
| busRelease | output | 1 | One-cycle end-of-tenure strobe |

## Verification
The delicate case is a completing data phase that coincides with a stop condition. In that cycle, the address advance and the count increment must happen together with the decision to release rather than start another address phase. The bench triggers this by changing FIFO levels, or pulsing preempt or end-of-packet, in exactly the cycle before a completing edge. In a separate case it pulses end-of-packet during an address phase, so the flag has to be remembered until a later completion. A behavioural model tracks every cycle, and each scenario's exact transfer count is compared with a value worked out by hand from the requirements.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_REL  = 2'd3
  } tenureState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture start values at grant
    logic advance;  // a transfer completed
    logic tick;     // timer decrement cycle
  } dpStrobe_t;
endpackage

// File: rtl/tenure_datapath.sv
module tenure_datapath
  import tenure_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BE_W        = 4,
  parameter int CNT_W       = 8,
  parameter int TMR_W       = 16,
  parameter int DEFAULT_CAP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dirIn,
  input  logic [CNT_W-1:0]  cfgXferLimit,
  input  logic [TMR_W-1:0]  cfgTimerLoad,
  output logic [ADDR_W-1:0] curAddr,
  output logic              curDir,
  output logic              capReached,
  output logic              timerZero
);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BE_W);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BE_W - 1);

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [TMR_W-1:0]  timerReg;
  logic              dirReg;
  logic [CNT_W-1:0]  effLimit;
  logic [CNT_W:0]    cntInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      cntReg   <= '0;
      timerReg <= '0;
      dirReg   <= 1'b0;
    end else if (strobe.load) begin
      addrReg  <= startAddr & ~LOW_MASK;
      cntReg   <= '0;
      timerReg <= cfgTimerLoad;
      dirReg   <= dirIn;
    end else begin
      if (strobe.advance) begin
        addrReg <= addrReg + STEP;
        cntReg  <= cntReg + CNT_W'(1);
      end
      if (strobe.tick && (timerReg != '0)) begin
        timerReg <= timerReg - TMR_W'(1);
      end
    end
  end

  always_comb begin
    effLimit   = (cfgXferLimit == '0) ? CNT_W'(DEFAULT_CAP) : cfgXferLimit;
    cntInc     = {1'b0, cntReg} + (CNT_W+1)'(1);
    capReached = (cntInc >= {1'b0, effLimit});
  end

  assign curAddr   = addrReg;
  assign curDir    = dirReg;
  assign timerZero = (timerReg == '0);
endmodule

// File: rtl/tenure_ctrl.sv
module tenure_ctrl
  import tenure_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int BE_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferPending,
  input  logic             busGrant,
  input  logic             tgtReady,
  input  logic             cfgRunMode,
  input  logic             curDir,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] txHighMark,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxLowMark,
  input  logic             preempt,
  input  logic             eopIn,
  input  logic             capReached,
  input  logic             timerZero,
  output dpStrobe_t        strobe,
  output logic             busReq,
  output logic             frameOut,
  output logic             xferValid,
  output logic [BE_W-1:0]  byteEn,
  output logic             busRelease
);
  tenureState_e state, stateNext;
  logic preSeen, eopSeen;
  logic inTenure, doneNow, wmHit, stopNow, startNow;

  always_comb begin
    inTenure = (state == ST_ADDR) || (state == ST_DATA);
    startNow = (state == ST_IDLE) && busGrant && xferPending;
    doneNow  = (state == ST_DATA) && tgtReady;
    wmHit    = curDir ? (rxLevel <= rxLowMark) : (txLevel >= txHighMark);
    stopNow  = preSeen || preempt || eopSeen || eopIn || timerZero || wmHit ||
               (!cfgRunMode && capReached);

    stateNext = state;
    unique case (state)
      ST_IDLE: if (startNow) stateNext = ST_ADDR;
      ST_ADDR: stateNext = ST_DATA;
      ST_DATA: if (tgtReady) stateNext = stopNow ? ST_REL : ST_ADDR;
      ST_REL:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase

    strobe.load    = startNow;
    strobe.advance = doneNow;
    strobe.tick    = inTenure;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preSeen <= 1'b0;
      eopSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (startNow) begin
        preSeen <= 1'b0;
        eopSeen <= 1'b0;
      end else if (inTenure) begin
        preSeen <= preSeen || preempt;
        eopSeen <= eopSeen || eopIn;
      end
    end
  end

  assign busReq     = ((state == ST_IDLE) && xferPending) || inTenure;
  assign frameOut   = (state == ST_ADDR);
  assign xferValid  = (state == ST_DATA);
  assign byteEn     = (state == ST_DATA) ? '1 : '0;
  assign busRelease = (state == ST_REL);
endmodule

// File: rtl/dma_tenure_ctrl.sv
module dma_tenure_ctrl
  import tenure_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LVL_W       = 8,
  parameter int CNT_W       = 8,
  parameter int TMR_W       = 16,
  parameter int DEFAULT_CAP = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  xferPending,
  input  logic                  busGrant,
  input  logic                  dirWrite,
  input  logic [ADDR_W-1:0]     startAddr,
  input  logic [LVL_W-1:0]      txLevel,
  input  logic [LVL_W-1:0]      txHighMark,
  input  logic [LVL_W-1:0]      rxLevel,
  input  logic [LVL_W-1:0]      rxLowMark,
  input  logic                  eopIn,
  input  logic                  preempt,
  input  logic                  tgtReady,
  input  logic                  cfgRunMode,
  input  logic [CNT_W-1:0]      cfgXferLimit,
  input  logic [TMR_W-1:0]      cfgTimerLoad,
  output logic                  busReq,
  output logic                  frameOut,
  output logic                  xferValid,
  output logic                  xferWrite,
  output logic [ADDR_W-1:0]     xferAddr,
  output logic [DATA_W/8-1:0]   byteEn,
  output logic                  busRelease
);
  localparam int BE_W = DATA_W / 8;

  dpStrobe_t strobe;
  logic      curDir, capReached, timerZero;

  tenure_ctrl #(.LVL_W(LVL_W), .BE_W(BE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .xferPending(xferPending), .busGrant(busGrant),
    .tgtReady(tgtReady), .cfgRunMode(cfgRunMode), .curDir(curDir),
    .txLevel(txLevel), .txHighMark(txHighMark), .rxLevel(rxLevel),
    .rxLowMark(rxLowMark), .preempt(preempt), .eopIn(eopIn),
    .capReached(capReached), .timerZero(timerZero), .strobe(strobe),
    .busReq(busReq), .frameOut(frameOut), .xferValid(xferValid),
    .byteEn(byteEn), .busRelease(busRelease)
  );

  tenure_datapath #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .CNT_W(CNT_W), .TMR_W(TMR_W),
    .DEFAULT_CAP(DEFAULT_CAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .dirIn(dirWrite), .cfgXferLimit(cfgXferLimit), .cfgTimerLoad(cfgTimerLoad),
    .curAddr(xferAddr), .curDir(curDir), .capReached(capReached),
    .timerZero(timerZero)
  );

  assign xferWrite = curDir;
endmodule

// File: rtl/tenure_chk.sv
module tenure_chk #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              frameOut,
  input logic              xferValid,
  input logic              busRelease,
  input logic              tgtReady,
  input logic              xferWrite,
  input logic [ADDR_W-1:0] xferAddr
);
  // R3
  frame_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameOut |=> (!frameOut && xferValid));

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameOut, xferValid, busRelease}));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !tgtReady) |=> (xferValid && $stable(xferAddr)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && tgtReady) |=>
      (busRelease || (frameOut && (xferAddr == $past(xferAddr) + ADDR_W'(STEP)))));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && tgtReady) |=> (busRelease || (xferWrite == $past(xferWrite))));

  // R11
  rel_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |=> (!busRelease && !frameOut && !xferValid));

  // R11
  rel_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |-> !busReq);
endmodule

bind dma_tenure_ctrl tenure_chk #(.ADDR_W(ADDR_W), .STEP(DATA_W/8)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .frameOut(frameOut),
  .xferValid(xferValid), .busRelease(busRelease), .tgtReady(tgtReady),
  .xferWrite(xferWrite), .xferAddr(xferAddr)
);

// File: tb/dma_tenure_ctrl_tb.sv
`timescale 1ns/1ps
module dma_tenure_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferPending = 0, busGrant = 0, dirWrite = 0;
  logic [31:0] startAddr = 0;
  logic [7:0]  txLevel = 0, txHighMark = 8'd200, rxLevel = 8'd200, rxLowMark = 0;
  logic        eopIn = 0, preempt = 0, tgtReady = 1, cfgRunMode = 0;
  logic [7:0]  cfgXferLimit = 0;
  logic [15:0] cfgTimerLoad = 16'd1000;
  logic        busReq, frameOut, xferValid, xferWrite, busRelease;
  logic [31:0] xferAddr;
  logic [3:0]  byteEn;

  int checks = 0, errors = 0, cyc = 0;
  bit stallOn = 0;

  always #4 clk = ~clk;

  dma_tenure_ctrl u_dut (
    .clk(clk), .rstN(rstN), .xferPending(xferPending), .busGrant(busGrant),
    .dirWrite(dirWrite), .startAddr(startAddr), .txLevel(txLevel),
    .txHighMark(txHighMark), .rxLevel(rxLevel), .rxLowMark(rxLowMark),
    .eopIn(eopIn), .preempt(preempt), .tgtReady(tgtReady),
    .cfgRunMode(cfgRunMode), .cfgXferLimit(cfgXferLimit),
    .cfgTimerLoad(cfgTimerLoad), .busReq(busReq), .frameOut(frameOut),
    .xferValid(xferValid), .xferWrite(xferWrite), .xferAddr(xferAddr),
    .byteEn(byteEn), .busRelease(busRelease)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ready pattern, changed just after the edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tgtReady <= stallOn ? ((cyc % 3) == 0) : 1'b1;
  end

  // behavioural reference: 0 idle, 1 address, 2 data, 3 release
  int mPh = 0, mCnt = 0, mTimer = 0;
  longint mAddr = 0;
  bit mDir = 0, mPre = 0, mEop = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mTimer = 0; mAddr = 0; mDir = 0; mPre = 0; mEop = 0;
    end else begin
      case (mPh)
        0: if (busGrant && xferPending) begin
             mPh = 1; mAddr = startAddr & 32'hFFFF_FFFC; mDir = dirWrite;
             mCnt = 0; mTimer = cfgTimerLoad; mPre = 0; mEop = 0;
           end
        1: begin
             mPh = 2; mPre |= preempt; mEop |= eopIn;
             if (mTimer > 0) mTimer--;
           end
        2: begin
             if (tgtReady) begin
               int lim;
               bit wm, stop;
               lim  = (cfgXferLimit == 0) ? 16 : int'(cfgXferLimit);
               mCnt++;
               wm   = mDir ? (rxLevel <= rxLowMark) : (txLevel >= txHighMark);
               stop = mPre || preempt || mEop || eopIn || (mTimer == 0) || wm ||
                      (!cfgRunMode && mCnt >= lim);
               mAddr = (mAddr + 4) & 32'hFFFF_FFFF;
               mPh = stop ? 3 : 1;
             end
             mPre |= preempt; mEop |= eopIn;
             if (mTimer > 0) mTimer--;
           end
        default: mPh = 0;
      endcase
    end
  end

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit eReq;
      eReq = (mPh == 0 && xferPending) || mPh == 1 || mPh == 2;
      chk(busReq === eReq, "R2 busReq", busReq, eReq);
      chk(frameOut === (mPh == 1), "R3 frameOut", frameOut, mPh == 1);
      chk(xferValid === (mPh == 2), "R4 xferValid", xferValid, mPh == 2);
      chk(busRelease === (mPh == 3), "R11 busRelease", busRelease, mPh == 3);
      chk(byteEn === ((mPh == 2) ? 4'hF : 4'h0), "R3 byteEn", byteEn, (mPh == 2) ? 4'hF : 4'h0);
      if (mPh == 1 || mPh == 2) begin
        chk(xferAddr === mAddr[31:0], "R5 xferAddr", xferAddr, mAddr);
        chk(xferWrite === mDir, "R6 xferWrite", xferWrite, mDir);
      end
    end
  end

  // one tenure; scen selects the stimulus hook; returns completions seen
  task automatic runTenure(input int scen, input longint expBase, output int n);
    bit seenFrame = 0;
    n = 0;
    @(negedge clk);
    xferPending = 1; busGrant = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (frameOut && !seenFrame) begin
        seenFrame = 1;
        chk(xferAddr == expBase[31:0], "R2 first address", xferAddr, expBase);
        if (scen == 4) dirWrite = 0;   // R6 change ignored
      end
      if (busRelease) break;
      if (xferValid && tgtReady) n++;
      case (scen)
        3: txLevel = 8'(2 * n);
        4: rxLevel = 8'(20 - 3 * n);
        6: preempt = xferValid && tgtReady && (n == 3);
        7: eopIn = frameOut && (n == 2);
        8: txLevel = 8'(2 * n);
        default: ;
      endcase
    end
    xferPending = 0; preempt = 0; eopIn = 0;
    chk(busRelease === 1'b1, "R11 release seen", busRelease, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!frameOut && !xferValid && !busRelease && !busReq && byteEn == 0,
        "R1 in reset", {frameOut, xferValid, busRelease, busReq}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(!frameOut && !xferValid && !busRelease && !busReq && byteEn == 0,
        "R1 after reset", {frameOut, xferValid, busRelease, busReq}, 0);

    // R2 request without grant starts nothing
    xferPending = 1;
    repeat (3) begin
      @(negedge clk);
      chk(busReq && !frameOut, "R2 no grant", {busReq, frameOut}, 2'b10);
    end
    xferPending = 0;
    @(negedge clk);

    // R7 capped at 5
    cfgRunMode = 0; cfgXferLimit = 5; startAddr = 32'h0000_1003;
    runTenure(1, 32'h1000, n);
    chk(n == 5, "R7 cap 5", n, 5);

    // R7 zero limit means 16
    cfgXferLimit = 0; startAddr = 32'h0000_2000;
    runTenure(2, 32'h2000, n);
    chk(n == 16, "R7 default cap", n, 16);

    // R8 run-on read stops at high watermark, count ignored
    cfgRunMode = 1; cfgXferLimit = 3; txHighMark = 12; txLevel = 0;
    startAddr = 32'h0000_3000;
    runTenure(3, 32'h3000, n);
    chk(n == 6, "R8 read watermark", n, 6);
    txLevel = 0; txHighMark = 200;

    // R8 run-on write stops at low watermark; R6 direction held
    dirWrite = 1; rxLevel = 20; rxLowMark = 5; startAddr = 32'h0000_4000;
    runTenure(4, 32'h4000, n);
    chk(n == 5, "R8 write watermark", n, 5);
    rxLevel = 200; rxLowMark = 0; dirWrite = 0;

    // R9 timer expiry
    cfgTimerLoad = 6; startAddr = 32'h0000_5000;
    runTenure(5, 32'h5000, n);
    chk(n == 4, "R9 timer", n, 4);
    cfgTimerLoad = 1000;

    // R10 preempt in completing cycle, with R4 stalls
    stallOn = 1; startAddr = 32'h0000_6000;
    runTenure(6, 32'h6000, n);
    chk(n == 3, "R10 preempt (R4 stalls)", n, 3);
    stallOn = 0;

    // R10 end-of-packet during an address phase is remembered
    cfgRunMode = 0; cfgXferLimit = 10; startAddr = 32'h0000_7000;
    runTenure(7, 32'h7000, n);
    chk(n == 3, "R10 eop latched", n, 3);

    // R8 watermark also ends a capped tenure early
    txHighMark = 6; txLevel = 0; startAddr = 32'h0000_8000;
    runTenure(8, 32'h8000, n);
    chk(n == 3, "R8 watermark in capped mode", n, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule